// File: doc/BRIEF.md
# Hysteretic Field Threshold Switch

This block turns a stream of signed digital magnetic-field samples into a single active-low switch output. The output turns on (goes low) when the field rises strictly above an operate threshold. It turns off (goes high) when the field falls strictly below a release threshold. Between the two thresholds the output keeps its last state, so noise and vibration near one threshold do not make it chatter. Positive samples stand for south-polarity field and negative samples for north-polarity field.

The operate threshold comes from a 6-bit code as `OP_BASE + OP_STEP * code`. The release threshold is the operate threshold minus a hysteresis that a 2-bit code selects. Once power-good is asserted, the output is forced on for a fixed number of microsecond ticks, whatever the field. After that interval the output starts from off and changes only on a real crossing of a threshold. If power-good drops, the power-on interval starts again from the beginning.

Top module: `field_threshold_switch`

## Requirements
- R1: A valid sample strictly greater than the operate threshold drives `sw_out_n` low on the clock edge that samples it. The operate threshold is `OP_BASE + OP_STEP * op_code` (default 10 + 5·code).
- R2: A valid sample strictly less than the release threshold drives `sw_out_n` high on the clock edge that samples it.
- R3: The release threshold is the operate threshold minus a hysteresis chosen by `hys_code`: 00 gives 30, 01 gives 40, 10 gives 60 and 11 gives 65. Both thresholds are registered, so a code change applies to samples taken from the second clock edge after the change onward.
- R4: While `rst` is high or `pwr_good` is low, `sw_out_n` is high from the next clock edge on.
- R5: After `pwr_good` rises, `sw_out_n` is held low regardless of samples until `HOLD_US` (default 25) `us_tick` pulses have been counted.
- R6: On the clock edge after the final hold tick is counted, `sw_out_n` goes high, unless a valid sample on that edge is above the operate threshold.
- R7: A valid sample equal to either threshold, or lying between them, leaves `sw_out_n` unchanged.
- R8: A drop of `pwr_good` during or after the hold interval discards the ticks already counted, and a full `HOLD_US` ticks are needed again.
- R9: A sample presented with `field_valid` low has no effect on `sw_out_n`.
- R10: Samples and thresholds are compared as signed two's-complement values, so a negative (north) sample below a negative release threshold turns the output off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pwr_good | input | 1 | Supply-valid flag; low restarts the power-on hold |
| us_tick | input | 1 | One-cycle pulse per microsecond |
| field_valid | input | 1 | Qualifies `field_sample` |
| field_sample | input | FIELD_W (16) | Signed field sample, south positive |
| op_code | input | OP_CODE_W (6) | Operate threshold code |
| hys_code | input | 2 | Hysteresis selection code |
| sw_out_n | output | 1 | Registered switch output, low = on |

## Verification
A valid sample changes `sw_out_n` on the same clock edge that takes it in. The bench therefore drives a sample on a falling edge and checks the output on the following falling edge. A code change needs one edge to reach the threshold registers, so the bench waits two cycles after changing a code before it sends samples. The hold interval ends one edge after the final tick is counted. The bench checks that the output is still low on the falling edge right after the final tick, and that it is high one cycle later.

// File: rtl/fts_pkg.sv
package fts_pkg;

  typedef enum logic [1:0] {
    HYS_NARROW  = 2'b00,
    HYS_MEDIUM  = 2'b01,
    HYS_WIDE    = 2'b10,
    HYS_WIDEST  = 2'b11
  } hys_sel_e;

  localparam int HYS_CODES = 4;

  // Hysteresis width in field units for each selection code.
  function automatic int hys_width(input hys_sel_e sel);
    case (sel)
      HYS_NARROW: return 30;
      HYS_MEDIUM: return 40;
      HYS_WIDE:   return 60;
      default:    return 65;
    endcase
  endfunction

endpackage

// File: rtl/fts_threshold_calc.sv
module fts_threshold_calc
  import fts_pkg::*;
#(
  parameter int FIELD_W   = 16,
  parameter int OP_CODE_W = 6,
  parameter int OP_BASE   = 10,
  parameter int OP_STEP   = 5,
  localparam int THR_W    = FIELD_W + 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [OP_CODE_W-1:0]    op_code_i,
  input  logic [1:0]              hys_code_i,
  output logic signed [THR_W-1:0] op_thr_o,
  output logic signed [THR_W-1:0] rp_thr_o
);

  int op_int;
  logic signed [THR_W-1:0] op_next;
  logic signed [THR_W-1:0] rp_cand [HYS_CODES];
  logic signed [THR_W-1:0] rp_next;

  always_comb begin
    op_int  = OP_BASE + OP_STEP * int'(op_code_i);
    op_next = THR_W'(op_int);
  end

  // One release candidate per hysteresis code, selected by the code.
  for (genvar g = 0; g < HYS_CODES; g++) begin : g_rp
    always_comb rp_cand[g] = THR_W'(op_int - hys_width(hys_sel_e'(g)));
  end

  always_comb rp_next = rp_cand[hys_code_i];

  always_ff @(posedge clk) begin
    if (rst) begin
      op_thr_o <= THR_W'(OP_BASE);
      rp_thr_o <= THR_W'(OP_BASE - hys_width(HYS_NARROW));
    end else begin
      op_thr_o <= op_next;
      rp_thr_o <= rp_next;
    end
  end

  // R3: the release threshold always sits strictly below the operate threshold
  a_r3_release_below_operate: assert property (@(posedge clk) disable iff (rst)
    rp_thr_o < op_thr_o);

  // R3: an unchanged operate code keeps the operate threshold stable
  a_r3_op_follows_code: assert property (@(posedge clk) disable iff (rst)
    $stable(op_code_i) |=> $stable(op_thr_o) || $past(rst));

endmodule

// File: rtl/fts_poweron_hold.sv
module fts_poweron_hold #(
  parameter int HOLD_US  = 25,
  localparam int CNT_W   = $clog2(HOLD_US + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic pwr_good_i,
  input  logic us_tick_i,
  output logic ready_o
);

  logic [CNT_W-1:0] tick_cnt;

  always_ff @(posedge clk) begin
    if (rst || !pwr_good_i) begin
      tick_cnt <= '0;
      ready_o  <= 1'b0;
    end else if (!ready_o && us_tick_i) begin
      tick_cnt <= tick_cnt + 1'b1;
      if (tick_cnt == CNT_W'(HOLD_US - 1)) ready_o <= 1'b1;
    end
  end

  // R5: the tick count never runs past the hold length
  a_r5_count_bounded: assert property (@(posedge clk) disable iff (rst)
    tick_cnt <= CNT_W'(HOLD_US));

  // R8: losing power-good clears the ready state on the next edge
  a_r8_restart_on_drop: assert property (@(posedge clk) disable iff (rst)
    !pwr_good_i |=> !ready_o);

  // R5: ready can only rise on a tick
  a_r5_ready_needs_tick: assert property (@(posedge clk) disable iff (rst)
    !ready_o ##1 ready_o |-> $past(us_tick_i));

endmodule

// File: rtl/fts_switch_core.sv
module fts_switch_core #(
  parameter int FIELD_W = 16,
  localparam int THR_W  = FIELD_W + 2
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      pwr_good_i,
  input  logic                      ready_i,
  input  logic                      valid_i,
  input  logic signed [FIELD_W-1:0] sample_i,
  input  logic signed [THR_W-1:0]   op_thr_i,
  input  logic signed [THR_W-1:0]   rp_thr_i,
  output logic                      out_n_o
);

  logic signed [THR_W-1:0] sample_ext;
  logic                    above_op;
  logic                    below_rp;
  logic                    was_ready;
  logic                    base_n;
  logic                    out_n_d;

  always_comb begin
    sample_ext = {{(THR_W-FIELD_W){sample_i[FIELD_W-1]}}, sample_i};
    above_op   = valid_i && (sample_ext > op_thr_i);
    below_rp   = valid_i && (sample_ext < rp_thr_i);
    // first ready cycle starts from off; later cycles keep the held state
    base_n     = was_ready ? out_n_o : 1'b1;
    if (above_op)      out_n_d = 1'b0;
    else if (below_rp) out_n_d = 1'b1;
    else               out_n_d = base_n;
  end

  always_ff @(posedge clk) begin
    if (rst || !pwr_good_i) begin
      out_n_o   <= 1'b1;
      was_ready <= 1'b0;
    end else if (!ready_i) begin
      out_n_o   <= 1'b0;
      was_ready <= 1'b0;
    end else begin
      out_n_o   <= out_n_d;
      was_ready <= 1'b1;
    end
  end

  // R4: no supply means the output is off
  a_r4_off_without_power: assert property (@(posedge clk) disable iff (rst)
    !pwr_good_i |=> out_n_o);

  // R5: during the hold the output is forced on
  a_r5_hold_forces_on: assert property (@(posedge clk) disable iff (rst)
    (pwr_good_i && !ready_i) |=> !out_n_o);

  // R1: excursion above operate turns the output on
  a_r1_turn_on: assert property (@(posedge clk) disable iff (rst)
    (pwr_good_i && ready_i && valid_i && (sample_ext > op_thr_i)) |=> !out_n_o);

  // R2: excursion below release turns the output off
  a_r2_turn_off: assert property (@(posedge clk) disable iff (rst)
    (pwr_good_i && ready_i && valid_i && (sample_ext < rp_thr_i)) |=> out_n_o);

  // R9: without a valid sample a settled output does not move
  a_r9_idle_holds: assert property (@(posedge clk) disable iff (rst)
    (pwr_good_i && ready_i && was_ready && !valid_i) |=> $stable(out_n_o));

endmodule

// File: rtl/field_threshold_switch.sv
module field_threshold_switch #(
  parameter int FIELD_W   = 16,
  parameter int OP_CODE_W = 6,
  parameter int OP_BASE   = 10,
  parameter int OP_STEP   = 5,
  parameter int HOLD_US   = 25
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      pwr_good,
  input  logic                      us_tick,
  input  logic                      field_valid,
  input  logic signed [FIELD_W-1:0] field_sample,
  input  logic [OP_CODE_W-1:0]      op_code,
  input  logic [1:0]                hys_code,
  output logic                      sw_out_n
);

  localparam int THR_W = FIELD_W + 2;

  logic signed [THR_W-1:0] op_thr;
  logic signed [THR_W-1:0] rp_thr;
  logic                    hold_ready;

  fts_threshold_calc #(
    .FIELD_W   (FIELD_W),
    .OP_CODE_W (OP_CODE_W),
    .OP_BASE   (OP_BASE),
    .OP_STEP   (OP_STEP)
  ) u_thr (
    .clk        (clk),
    .rst        (rst),
    .op_code_i  (op_code),
    .hys_code_i (hys_code),
    .op_thr_o   (op_thr),
    .rp_thr_o   (rp_thr)
  );

  fts_poweron_hold #(
    .HOLD_US (HOLD_US)
  ) u_hold (
    .clk        (clk),
    .rst        (rst),
    .pwr_good_i (pwr_good),
    .us_tick_i  (us_tick),
    .ready_o    (hold_ready)
  );

  fts_switch_core #(
    .FIELD_W (FIELD_W)
  ) u_core (
    .clk        (clk),
    .rst        (rst),
    .pwr_good_i (pwr_good),
    .ready_i    (hold_ready),
    .valid_i    (field_valid),
    .sample_i   (field_sample),
    .op_thr_i   (op_thr),
    .rp_thr_i   (rp_thr),
    .out_n_o    (sw_out_n)
  );

endmodule

// File: tb/field_threshold_switch_tb.sv
module field_threshold_switch_tb;

  localparam int HOLD = 25;

  logic               clk = 1'b0;
  logic               rst = 1'b1;
  logic               pwr_good = 1'b0;
  logic               us_tick = 1'b0;
  logic               field_valid = 1'b0;
  logic signed [15:0] field_sample = '0;
  logic [5:0]         op_code = '0;
  logic [1:0]         hys_code = '0;
  logic               sw_out_n;

  int n_checks = 0;
  int n_fail   = 0;
  bit done_run = 1'b0;

  always #4 clk = ~clk;

  field_threshold_switch u_dut (
    .clk          (clk),
    .rst          (rst),
    .pwr_good     (pwr_good),
    .us_tick      (us_tick),
    .field_valid  (field_valid),
    .field_sample (field_sample),
    .op_code      (op_code),
    .hys_code     (hys_code),
    .sw_out_n     (sw_out_n)
  );

  function automatic int exp_op(input int code);
    return 10 + 5 * code;
  endfunction

  function automatic int exp_rp(input int code, input int hc);
    int h;
    case (hc)
      0: h = 30;
      1: h = 40;
      2: h = 60;
      default: h = 65;
    endcase
    return exp_op(code) - h;
  endfunction

  task automatic check(input string req, input logic exp);
    n_checks++;
    if (sw_out_n !== exp) begin
      n_fail++;
      $display("FAIL %s: sw_out_n=%b expected %b at %0t", req, sw_out_n, exp, $time);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic send(input int value, input logic vld);
    @(negedge clk);
    field_valid  = vld;
    field_sample = 16'(value);
    @(negedge clk);
    field_valid  = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); us_tick = 1'b1;
      @(negedge clk); us_tick = 1'b0;
    end
  endtask

  task automatic set_codes(input int oc, input int hc);
    @(negedge clk);
    op_code  = 6'(oc);
    hys_code = 2'(hc);
    idle(2);
  endtask

  task automatic t_reset;
    idle(3);
    check("R4 reset", 1'b1);
    rst = 1'b0;
    idle(2);
    check("R4 no power", 1'b1);
  endtask

  task automatic t_powerup;
    pwr_good = 1'b1;
    idle(2);
    check("R5 hold start", 1'b0);
    send(3000, 1'b1);
    check("R5 sample ignored in hold", 1'b0);
    send(-3000, 1'b1);
    check("R5 low sample ignored in hold", 1'b0);
    ticks(HOLD - 1);
    check("R5 one tick short", 1'b0);
    @(negedge clk); us_tick = 1'b1;
    @(negedge clk); us_tick = 1'b0;
    check("R5 last tick edge", 1'b0);
    @(negedge clk);
    check("R6 band start off", 1'b1);
  endtask

  task automatic t_basic;
    int op, rp;
    set_codes(2, 0);
    op = exp_op(2); rp = exp_rp(2, 0);
    send(op, 1'b1);
    check("R7 equal operate", 1'b1);
    send(op + 1, 1'b1);
    check("R1 above operate", 1'b0);
    send(0, 1'b1);
    check("R7 inside band", 1'b0);
    send(rp, 1'b1);
    check("R7 equal release", 1'b0);
    send(500, 1'b0);
    send(rp - 1, 1'b0);
    check("R9 invalid ignored", 1'b0);
    send(rp - 1, 1'b1);
    check("R2 R10 negative below release", 1'b1);
    send(500, 1'b0);
    check("R9 invalid high field ignored", 1'b1);
  endtask

  task automatic t_hys_table;
    for (int hc = 0; hc < 4; hc++) begin
      set_codes(63, hc);
      send(exp_op(63), 1'b1);
      check("R3 max code equal", 1'b1);
      send(exp_op(63) + 1, 1'b1);
      check("R3 max code above", 1'b0);
      send(exp_rp(63, hc), 1'b1);
      check("R3 release equal", 1'b0);
      send(exp_rp(63, hc) - 1, 1'b1);
      check("R3 release below", 1'b1);
    end
    set_codes(0, 3);
    send(11, 1'b1);
    check("R3 min code above", 1'b0);
    send(-55, 1'b1);
    check("R10 negative release equal", 1'b0);
    send(-56, 1'b1);
    check("R10 negative release below", 1'b1);
  endtask

  task automatic t_restart;
    send(200, 1'b1);
    check("R1 on before drop", 1'b0);
    @(negedge clk); pwr_good = 1'b0;
    @(negedge clk);
    check("R4 drop off", 1'b1);
    @(negedge clk); pwr_good = 1'b1;
    @(negedge clk);
    check("R8 hold again", 1'b0);
    ticks(10);
    @(negedge clk); pwr_good = 1'b0;
    @(negedge clk); pwr_good = 1'b1;
    ticks(HOLD - 1);
    check("R8 partial count discarded", 1'b0);
    ticks(1);
    @(negedge clk);
    check("R8 R6 full hold completes", 1'b1);
  endtask

  initial begin
    t_reset();
    t_powerup();
    t_basic();
    t_hys_table();
    t_restart();
    done_run = 1'b1;
  end

  initial begin
    for (int c = 0; c < 20000 && !done_run; c++) @(posedge clk);
    if (!done_run) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: run did not finish, expected completion");
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

endmodule